// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level page table kept in ordinary memory. A caller presents a request made of a virtual address, an access kind (read, write, execute) and a privilege flag. The block then reads at most two table entries through a simple word read port that has a ready handshake. It returns either the physical address or a fault code, together with the table level at which the fault arose.

Pages are 1 KB in size, so the low 10 address bits pass through unchanged. The upper 22 bits split into a 12-bit outer index and a 10-bit inner index. A base input locates the outer table, and a length input bounds how many outer entries exist.

Every entry carries a valid bit, three access-right bits and a user-access bit. Both levels must grant the access, so an outer entry can fence off a whole 1 MB region.

Entries are 32 bits wide and use these bits:
- bit 0: valid
- bit 1: read allowed
- bit 2: write allowed
- bit 3: execute allowed
- bit 4: user accessible
- bits 31:12 of an outer entry: the inner table base, which is 4 KB aligned
- bits 31:10 of an inner entry: the frame number

Top module: `pgwalk_top`

## Requirements
- R1: A successful walk returns rspPaddr = {inner entry bits 31:10, virtual address bits 9:0} with rspFault=0 and rspCode=0.
- R2: The first read is at tblBase + 4*vaddr[31:20]. The second read is at {outer entry bits 31:12, 12'b0} + 4*vaddr[19:10].
- R3: If vaddr[31:20] >= tblLimit, the block ends the walk with rspCode=1 (length) and rspLevel=0, and issues no memory read.
- R4: An entry with bit 0 clear ends the walk with rspCode=2 (not present). rspLevel is 0 for the outer entry and 1 for the inner entry.
- R5: reqAcc 0 (read) needs bit 1, 1 (write) needs bit 2 and 2 (execute) needs bit 3; value 3 is never granted. Both levels are checked, and a missing right gives rspCode=3 at that level.
- R6: When reqUser=1, an entry with bit 4 clear gives rspCode=4. When reqUser=0, bit 4 is ignored. At one entry the priority is: not present, then privilege, then rights.
- R7: memReq stays high with a stable memAddr until memReady is seen. The walk waits any number of cycles for memReady.
- R8: A request is taken only while reqReady is high, which is only when the block is idle. reqValid during a walk is ignored.
- R9: Each accepted request gives exactly one single-cycle rspValid pulse, and reqReady is high in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tblBase | input | 32 | Byte address of the outer table |
| tblLimit | input | 13 | Number of valid outer entries |
| reqValid | input | 1 | Translation request strobe |
| reqReady | output | 1 | Block is idle and takes a request |
| reqVaddr | input | 32 | Virtual address |
| reqAcc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| reqUser | input | 1 | Request comes from user mode |
| memReq | output | 1 | Table entry read request |
| memAddr | output | 32 | Byte address of the entry |
| memReady | input | 1 | Read data valid; completes the read |
| memData | input | 32 | Entry read from memory |
| rspValid | output | 1 | One-cycle result strobe |
| rspFault | output | 1 | Result is a fault |
| rspCode | output | 3 | 0 ok, 1 length, 2 not present, 3 rights, 4 privilege |
| rspLevel | output | 1 | Table level of the fault |
| rspPaddr | output | 32 | Physical address on success |

## Verification
The assertions assume three things about the inputs:
- tblBase and tblLimit stay constant while a walk is in progress, so the address-stability property measures the block and not a moving base.
- memReady is only given while memReq is high.
- memReady arrives eventually.

The bench meets these assumptions as follows:
- It writes the table base and limit once, before any request.
- Its memory responder raises memReady only in answer to an open read, and only after a set latency.
- It lowers memReady on the next cycle.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  localparam int FLAG_V = 0;
  localparam int FLAG_R = 1;
  localparam int FLAG_W = 2;
  localparam int FLAG_X = 3;
  localparam int FLAG_U = 4;
  localparam int FLAG_W_TOTAL = 5;

  localparam logic [1:0] ACC_READ  = 2'd0;
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_EXEC  = 2'd2;

  localparam logic [2:0] FC_NONE    = 3'd0;
  localparam logic [2:0] FC_LENGTH  = 3'd1;
  localparam logic [2:0] FC_INVALID = 3'd2;
  localparam logic [2:0] FC_RIGHTS  = 3'd3;
  localparam logic [2:0] FC_PRIV    = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_L1,
    ST_FETCH_L2,
    ST_DONE,
    ST_FAULT
  } walkState_t;

  typedef struct packed {
    logic       loadReq;
    logic       loadL1;
    logic       loadL2;
    logic       latchFault;
    logic       faultLvl;
    logic [2:0] faultCode;
    logic       selL2;
  } walkCtl_t;

  // Judge one entry against the access; priority: present, privilege, rights.
  function automatic logic [2:0] checkEntry(input logic [FLAG_W_TOTAL-1:0] flags,
                                            input logic [1:0] acc,
                                            input logic user);
    logic granted;
    case (acc)
      ACC_READ:  granted = flags[FLAG_R];
      ACC_WRITE: granted = flags[FLAG_W];
      ACC_EXEC:  granted = flags[FLAG_X];
      default:   granted = 1'b0;
    endcase
    if (!flags[FLAG_V])               return FC_INVALID;
    else if (user && !flags[FLAG_U])  return FC_PRIV;
    else if (!granted)                return FC_RIGHTS;
    else                              return FC_NONE;
  endfunction

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       lenBad,
  input  logic       memReady,
  input  logic [2:0] entryCode,
  output logic       reqReady,
  output logic       memReq,
  output logic       rspValid,
  output logic       rspFault,
  output walkCtl_t   ctl
);

  walkState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadReq = 1'b1;
          if (lenBad) begin
            ctl.latchFault = 1'b1;
            ctl.faultCode  = FC_LENGTH;
            ctl.faultLvl   = 1'b0;
            stateNext      = ST_FAULT;
          end else begin
            stateNext = ST_FETCH_L1;
          end
        end
      end
      ST_FETCH_L1: begin
        if (memReady) begin
          if (entryCode != FC_NONE) begin
            ctl.latchFault = 1'b1;
            ctl.faultCode  = entryCode;
            ctl.faultLvl   = 1'b0;
            stateNext      = ST_FAULT;
          end else begin
            ctl.loadL1 = 1'b1;
            stateNext  = ST_FETCH_L2;
          end
        end
      end
      ST_FETCH_L2: begin
        ctl.selL2 = 1'b1;
        if (memReady) begin
          if (entryCode != FC_NONE) begin
            ctl.latchFault = 1'b1;
            ctl.faultCode  = entryCode;
            ctl.faultLvl   = 1'b1;
            stateNext      = ST_FAULT;
          end else begin
            ctl.loadL2 = 1'b1;
            stateNext  = ST_DONE;
          end
        end
      end
      ST_DONE:  stateNext = ST_IDLE;
      ST_FAULT: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign memReq   = (state == ST_FETCH_L1) || (state == ST_FETCH_L2);
  assign rspValid = (state == ST_DONE) || (state == ST_FAULT);
  assign rspFault = (state == ST_FAULT);

  // R9: the result strobe lasts one cycle and the block is idle right after
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  a_r9_ready_after: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  // R3: a length violation never reaches memory
  a_r3_len_no_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && lenBad) |=> (rspFault && !memReq));

  // R7: an open read stays open until memory answers
  a_r7_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> memReq);

  // R1: a successful result always follows a completed read
  a_r1_done_after_read: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> $past(memReq && memReady));

  // R8: a request arriving during a walk does not restart it
  a_r8_busy_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady && reqValid) |=> memReq);

endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10,
  parameter int IDX2_W = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  walkCtl_t                      ctl,
  input  logic [ADDR_W-1:0]             tblBase,
  input  logic [ADDR_W-OFF_W-IDX2_W:0]  tblLimit,
  input  logic [ADDR_W-1:0]             reqVaddr,
  input  logic [1:0]                    reqAcc,
  input  logic                          reqUser,
  input  logic [ADDR_W-1:0]             memData,
  output logic                          lenBad,
  output logic [2:0]                    entryCode,
  output logic [ADDR_W-1:0]             memAddr,
  output logic [2:0]                    rspCode,
  output logic                          rspLevel,
  output logic [ADDR_W-1:0]             rspPaddr
);

  localparam int IDX1_W   = ADDR_W - OFF_W - IDX2_W;
  localparam int TBL2_W   = IDX2_W + 2;          // byte span of an inner table
  localparam int FRAME_W  = ADDR_W - OFF_W;

  logic [ADDR_W-1:0]  vaddrQ;
  logic [1:0]         accQ;
  logic               userQ;
  logic [ADDR_W-1:0]  tbl2BaseQ;
  logic [FRAME_W-1:0] frameQ;
  logic [2:0]         codeQ;
  logic               lvlQ;

  logic [IDX1_W-1:0]  idx1;
  logic [IDX2_W-1:0]  idx2;
  logic [ADDR_W-1:0]  l1Addr;
  logic [ADDR_W-1:0]  l2Addr;

  assign lenBad = {1'b0, reqVaddr[ADDR_W-1 -: IDX1_W]} >= tblLimit;

  assign idx1   = vaddrQ[ADDR_W-1 -: IDX1_W];
  assign idx2   = vaddrQ[OFF_W +: IDX2_W];
  assign l1Addr = tblBase   + {{(ADDR_W-IDX1_W-2){1'b0}}, idx1, 2'b00};
  assign l2Addr = tbl2BaseQ + {{(ADDR_W-IDX2_W-2){1'b0}}, idx2, 2'b00};
  assign memAddr = ctl.selL2 ? l2Addr : l1Addr;

  assign entryCode = checkEntry(memData[FLAG_W_TOTAL-1:0], accQ, userQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      accQ      <= '0;
      userQ     <= 1'b0;
      tbl2BaseQ <= '0;
      frameQ    <= '0;
      codeQ     <= FC_NONE;
      lvlQ      <= 1'b0;
    end else begin
      if (ctl.loadReq) begin
        vaddrQ <= reqVaddr;
        accQ   <= reqAcc;
        userQ  <= reqUser;
        codeQ  <= FC_NONE;
        lvlQ   <= 1'b0;
      end
      if (ctl.loadL1)
        tbl2BaseQ <= {memData[ADDR_W-1:TBL2_W], {TBL2_W{1'b0}}};
      if (ctl.loadL2)
        frameQ <= memData[ADDR_W-1:OFF_W];
      if (ctl.latchFault) begin
        codeQ <= ctl.faultCode;
        lvlQ  <= ctl.faultLvl;
      end
    end
  end

  assign rspCode  = codeQ;
  assign rspLevel = lvlQ;
  assign rspPaddr = {frameQ, vaddrQ[OFF_W-1:0]};

  // R4/R6: a latched entry fault never carries the length code
  a_r4_entry_code: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.latchFault && !ctl.loadReq) |=> (rspCode != FC_LENGTH && rspCode != FC_NONE));

  // R1: the page offset of a finished walk equals the requested offset
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadL2 |=> (rspPaddr[OFF_W-1:0] == $past(vaddrQ[OFF_W-1:0])));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 10,
  parameter int IDX2_W = 10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [ADDR_W-1:0]             tblBase,
  input  logic [ADDR_W-OFF_W-IDX2_W:0]  tblLimit,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ADDR_W-1:0]             reqVaddr,
  input  logic [1:0]                    reqAcc,
  input  logic                          reqUser,
  output logic                          memReq,
  output logic [ADDR_W-1:0]             memAddr,
  input  logic                          memReady,
  input  logic [ADDR_W-1:0]             memData,
  output logic                          rspValid,
  output logic                          rspFault,
  output logic [2:0]                    rspCode,
  output logic                          rspLevel,
  output logic [ADDR_W-1:0]             rspPaddr
);

  walkCtl_t   ctl;
  logic       lenBad;
  logic [2:0] entryCode;

  pgwalk_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .lenBad    (lenBad),
    .memReady  (memReady),
    .entryCode (entryCode),
    .reqReady  (reqReady),
    .memReq    (memReq),
    .rspValid  (rspValid),
    .rspFault  (rspFault),
    .ctl       (ctl)
  );

  pgwalk_dpath #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .IDX2_W (IDX2_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .tblBase   (tblBase),
    .tblLimit  (tblLimit),
    .reqVaddr  (reqVaddr),
    .reqAcc    (reqAcc),
    .reqUser   (reqUser),
    .memData   (memData),
    .lenBad    (lenBad),
    .entryCode (entryCode),
    .memAddr   (memAddr),
    .rspCode   (rspCode),
    .rspLevel  (rspLevel),
    .rspPaddr  (rspPaddr)
  );

  // R7: address held steady while a read waits (base held constant by caller)
  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr));

endmodule

// File: tb/sim_pgwalk_top.sv
`timescale 1ns/1ps
module sim_pgwalk_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] tblBase = 32'h0000_1000;
  logic [12:0] tblLimit = 13'd16;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [1:0]  reqAcc = '0;
  logic        reqUser = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memReady = 1'b0;
  logic [31:0] memData = '0;
  logic        rspValid, rspFault, rspLevel;
  logic [2:0]  rspCode;
  logic [31:0] rspPaddr;

  always #4 clk = ~clk;   // 125 MHz

  pgwalk_top u0 (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  // ---------------- memory model ----------------
  logic [31:0] mem [int unsigned];
  int          latency = 0;
  int          waitCnt = 0;
  int          rdCount = 0;
  logic [31:0] addrLog [0:3];
  logic [31:0] firstAddr;
  bit          addrMoved = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      memReady = 1'b0; waitCnt = 0;
    end else if (memReady) begin
      memReady = 1'b0; waitCnt = 0;
    end else if (memReq) begin
      if (waitCnt == 0) firstAddr = memAddr;
      else if (memAddr != firstAddr) addrMoved = 1;
      if (waitCnt >= latency) begin
        memReady = 1'b1;
        memData  = rd(memAddr);
        if (rdCount < 4) addrLog[rdCount] = memAddr;
        rdCount++;
      end else begin
        waitCnt++;
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkva(input int outer, input int inner, input int off);
    return (32'(outer) << 20) | (32'(inner) << 10) | 32'(off);
  endfunction

  logic        gF, gLvl;
  logic [2:0]  gCode;
  logic [31:0] gPa;

  task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic usr);
    int n;
    @(negedge clk);
    rdCount = 0; addrMoved = 0;
    chk(reqReady, "R8", "ready before request", reqReady, 1);
    reqVaddr = va; reqAcc = acc; reqUser = usr; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspValid && n < 200) begin @(negedge clk); n++; end
    gF = rspFault; gCode = rspCode; gLvl = rspLevel; gPa = rspPaddr;
    @(negedge clk);
    chk(!rspValid && reqReady, "R9", "pulse then ready", {rspValid, reqReady}, 2'b01);
  endtask

  task automatic expectOk(input string tag, input logic [31:0] pa);
    chk(!gF && gCode == 3'd0, tag, "no fault", {gF, gCode}, 0);
    chk(gPa == pa, tag, "paddr", gPa, pa);
  endtask

  task automatic expectFault(input string tag, input logic [2:0] code, input logic lvl, input int reads);
    chk(gF, tag, "fault flag", gF, 1);
    chk(gCode == code, tag, "fault code", gCode, code);
    chk(gLvl == lvl, tag, "fault level", gLvl, lvl);
    chk(rdCount == reads, tag, "read count", rdCount, reads);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(reqReady == 1, "R8", "reset ready", reqReady, 1);
    chk(rspValid == 0, "R9", "reset rspValid", rspValid, 0);
    chk(memReq == 0, "R7", "reset memReq", memReq, 0);
  endtask

  task automatic t_good_read;   // R1, R2
    latency = 0;
    walk(mkva(3, 5, 'h123), 2'd0, 1'b0);
    expectOk("R1", 32'h02AF_3523);
    chk(rdCount == 2, "R2", "two reads", rdCount, 2);
    chk(addrLog[0] == 32'h1000 + 3*4, "R2", "outer addr", addrLog[0], 32'h100C);
    chk(addrLog[1] == 32'h4_0000 + 5*4, "R2", "inner addr", addrLog[1], 32'h4_0014);
  endtask

  task automatic t_slow_memory; // R7
    latency = 3;
    walk(mkva(3, 5, 'h3FF), 2'd1, 1'b1);
    expectOk("R7", 32'h02AF_37FF);
    chk(!addrMoved, "R7", "address steady while waiting", addrMoved, 0);
    walk(mkva(3, 5, 'h001), 2'd2, 1'b0);
    expectOk("R5", 32'h02AF_3401);
    latency = 0;
  endtask

  task automatic t_length;      // R3
    walk(mkva(16, 0, 0), 2'd0, 1'b0);
    expectFault("R3", 3'd1, 1'b0, 0);
    walk(mkva(15, 0, 0), 2'd0, 1'b0);   // inside limit, outer entry absent
    expectFault("R3", 3'd2, 1'b0, 1);
  endtask

  task automatic t_invalid;     // R4
    walk(mkva(4, 0, 0), 2'd0, 1'b0);
    expectFault("R4", 3'd2, 1'b0, 1);
    walk(mkva(3, 6, 0), 2'd0, 1'b0);
    expectFault("R4", 3'd2, 1'b1, 2);
  endtask

  task automatic t_rights;      // R5
    walk(mkva(3, 7, 0), 2'd1, 1'b0);
    expectFault("R5", 3'd3, 1'b1, 2);
    walk(mkva(3, 7, 0), 2'd0, 1'b0);
    expectOk("R5", 32'h001D_DC00);
    walk(mkva(3, 5, 0), 2'd3, 1'b0);
    expectFault("R5", 3'd3, 1'b0, 1);
    walk(mkva(5, 5, 0), 2'd1, 1'b0);
    expectFault("R5", 3'd3, 1'b0, 1);
    walk(mkva(5, 5, 'h123), 2'd0, 1'b0);
    expectOk("R5", 32'h02AF_3523);
  endtask

  task automatic t_priv;        // R6
    walk(mkva(3, 8, 0), 2'd0, 1'b1);
    expectFault("R6", 3'd4, 1'b1, 2);
    walk(mkva(3, 8, 'h3FF), 2'd0, 1'b0);
    expectOk("R6", 32'h0015_57FF);
    walk(mkva(6, 5, 0), 2'd0, 1'b1);
    expectFault("R6", 3'd4, 1'b0, 1);
    walk(mkva(3, 9, 0), 2'd0, 1'b1);
    expectFault("R6", 3'd2, 1'b1, 2);
    walk(mkva(3, 10, 0), 2'd1, 1'b1);
    expectFault("R6", 3'd4, 1'b1, 2);
  endtask

  task automatic t_busy;        // R8
    int n;
    int pulses;
    latency = 4;
    @(negedge clk);
    rdCount = 0;
    reqVaddr = mkva(3, 5, 'h0AA); reqAcc = 2'd0; reqUser = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!reqReady, "R8", "not ready while walking", reqReady, 0);
    reqVaddr = mkva(16, 0, 0); reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    n = 0;
    while (!rspValid && n < 200) begin @(negedge clk); n++; end
    chk(!rspFault && rspPaddr == 32'h02AF_34AA, "R8", "first request result",
        rspPaddr, 32'h02AF_34AA);
    pulses = 0;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (rspValid) pulses++; end
    chk(pulses == 0, "R8", "no response to ignored request", pulses, 0);
    chk(rdCount == 2 && !memReq, "R8", "no extra reads", rdCount, 2);
    latency = 0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    mem[32'h0000_100C] = 32'h0004_001F;
    mem[32'h0000_1014] = 32'h0004_001B;
    mem[32'h0000_1018] = 32'h0004_000F;
    mem[32'h0004_0014] = 32'h02AF_341F;
    mem[32'h0004_001C] = 32'h001D_DC13;
    mem[32'h0004_0020] = 32'h0015_540F;
    mem[32'h0004_0024] = 32'h0000_000E;
    mem[32'h0004_0028] = 32'h0000_0003;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_good_read();
    t_slow_memory();
    t_length();
    t_invalid();
    t_rights();
    t_priv();
    t_busy();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule